// File: doc/BRIEF.md
# Power-Fail Protected Two-Bank SRAM Controller

This block is the synchronous control logic that sits between a byte-wide host bus and a battery-backed memory made of two half-size banks. The host drives active-low chip enable, write enable and output enable, together with a 20-bit byte address. The controller decodes the top address bit into one chip enable per bank, passes the remaining address bits through as the in-bank address, and produces a gated write strobe and a data-output enable for the tristate data bus.

Three digitized supply flags come from external comparators: supply above the fail threshold, above the battery switchover level, and above the full-function level. When the supply is below the fail threshold, the controller ignores the host, aborts any access in progress and tristates the bus. After power returns, access resumes only once the full-function flag is seen. Reaching the fail threshold again is not enough. A separate registered output selects the battery whenever the supply is under the switchover level. After each write, a recovery window of a set number of clock cycles blocks new accesses. Any request made inside that window is reported on a protocol-error output.

Top module: `pfsram_ctrl`

## Requirements
- R1: While `rst` is high, and on the first sampled edge after `rst`, all bank enables are high, `wr_strobe_n` is high, `dout_en` and `proto_err` are low, and `bat_sel` is high.
- R2: In the run state, with `ce_n`=0, `we_n`=1 and `oe_n`=0, the next clock edge drives the addressed bank enable low and `dout_en` high, and `wr_strobe_n` stays high.
- R3: Address bit 19 steers the access: a value of 0 selects bank 0 (`bank_ce_n[0]` low) and a value of 1 selects bank 1 (`bank_ce_n[1]` low). At most one bank enable is low at a time. `mem_addr` carries address bits 18:0 of the granted access.
- R4: `wr_strobe_n` is low on the edge after a cycle in which `ce_n` and `we_n` are both low and the access is granted. It is high otherwise, so the write lasts from the later falling edge of the two inputs to the earlier rising edge.
- R5: A granted request with `we_n` low never asserts `dout_en`, even when `oe_n` is low. Lowering `we_n` during a read turns the output off on the next edge.
- R6: When `sup_ok` is low, the next edge drives all bank enables high, `wr_strobe_n` high, `dout_en` low and `proto_err` low, whatever the host inputs are. An access in progress is cut off at once, and any recovery window is cleared.
- R7: Leaving the locked state needs `sup_ok` and `sup_full` both high. After that, the run state holds while `sup_ok` stays high, even if `sup_full` drops.
- R8: `bat_sel` is the inverse of `sup_sw`, registered with one edge of delay.
- R9: After a write ends, RECOV_CYC clock edges (default 2) grant no access. A request (`ce_n` low) made during that window, including the cycle in which `we_n` rises, is held off, and `proto_err` goes high on the next edge.
- R10: `dout_en` goes high only when `oe_n` is low. A granted read with `oe_n` high still enables the bank but leaves the bus off.
- R11: `proto_err` is never high while the supply is locked out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| addr | input | 20 | Host byte address |
| sup_ok | input | 1 | Supply above fail threshold |
| sup_sw | input | 1 | Supply above battery switchover level |
| sup_full | input | 1 | Supply above full-function level |
| bank_ce_n | output | 2 | Per-bank chip enables, active low |
| mem_addr | output | 19 | In-bank address |
| wr_strobe_n | output | 1 | Gated write strobe, active low |
| dout_en | output | 1 | Data bus output enable |
| bat_sel | output | 1 | Battery selected as memory supply |
| proto_err | output | 1 | Request made inside the recovery window |

## Verification
The bench cuts the supply in the middle of a write. A design that finishes the write, or that keeps a recovery window running into the next power-up, either corrupts the shadow memory or blocks the first read after power returns. The bench raises the supply only to the fail threshold and checks that access stays locked, which catches a design that resumes too early. It issues reads inside the recovery window, both back to back and after a strobe, and pulls write enable low during an active read. Each of these exposes a miscounted window or bus contention. Two writes go to the same in-bank address in different banks and are read back, so a swapped bank decode returns the wrong byte.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {
    PWR_LOCK = 1'b0,
    PWR_RUN  = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pf_supply_mon.sv
module pf_supply_mon
  import pf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sup_ok,
  input  logic sup_sw,
  input  logic sup_full,
  output logic run_nxt,
  output logic bat_sel
);
  pwr_state_e state_q, state_d;

  // lock on fail, unlock only on full-function level, hold otherwise
  always_comb begin
    state_d = state_q;
    if (!sup_ok)       state_d = PWR_LOCK;
    else if (sup_full) state_d = PWR_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PWR_LOCK;
      bat_sel <= 1'b1;
    end else begin
      state_q <= state_d;
      bat_sel <= ~sup_sw;
    end
  end

  assign run_nxt = (state_d == PWR_RUN);
endmodule

// File: rtl/pf_bank_dec.sv
module pf_bank_dec #(
  parameter int BANK_BITS = 1
) (
  input  logic                      en,
  input  logic [BANK_BITS-1:0]      sel,
  output logic [(1<<BANK_BITS)-1:0] bank_n
);
  localparam int NB = 1 << BANK_BITS;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_n[b] = ~(en && (sel == BANK_BITS'(b)));
  end
endmodule

// File: rtl/pf_access_ctrl.sv
module pf_access_ctrl #(
  parameter int ADDR_W    = 20,
  parameter int BANK_BITS = 1,
  parameter int RECOV_CYC = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  logic                      ce_n,
  input  logic                      we_n,
  input  logic                      oe_n,
  input  logic [ADDR_W-1:0]         addr,
  output logic [(1<<BANK_BITS)-1:0] bank_ce_n,
  output logic [ADDR_W-BANK_BITS-1:0] mem_addr,
  output logic                      wr_strobe_n,
  output logic                      dout_en,
  output logic                      proto_err
);
  localparam int NB    = 1 << BANK_BITS;
  localparam int LOW_W = ADDR_W - BANK_BITS;
  localparam int CNT_W = (RECOV_CYC > 0) ? $clog2(RECOV_CYC + 1) : 1;

  logic [CNT_W-1:0] rec_q;
  logic             wr_q;
  logic             busy, grant, wr_d, rd_d, err_d;
  logic [NB-1:0]    dec_n;

  // recovery covers the counter and the cycle in which the write ends
  assign busy  = (rec_q != '0) || (wr_q && we_n);
  assign grant = run && !ce_n && !busy;
  assign wr_d  = grant && !we_n;
  assign rd_d  = grant && we_n && !oe_n;
  assign err_d = run && !ce_n && busy;

  pf_bank_dec #(.BANK_BITS(BANK_BITS)) u_dec (
    .en     (grant),
    .sel    (addr[ADDR_W-1 -: BANK_BITS]),
    .bank_n (dec_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q       <= '0;
      wr_q        <= 1'b0;
      bank_ce_n   <= '1;
      mem_addr    <= '0;
      wr_strobe_n <= 1'b1;
      dout_en     <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      wr_q        <= wr_d;
      bank_ce_n   <= dec_n;
      wr_strobe_n <= ~wr_d;
      dout_en     <= rd_d;
      proto_err   <= err_d;
      if (grant) mem_addr <= addr[LOW_W-1:0];
      if (!run)                rec_q <= '0;
      else if (wr_q && !wr_d)  rec_q <= CNT_W'(RECOV_CYC);
      else if (rec_q != '0)    rec_q <= rec_q - 1'b1;
    end
  end
endmodule

// File: rtl/pfsram_ctrl.sv
module pfsram_ctrl #(
  parameter int ADDR_W    = 20,
  parameter int BANK_BITS = 1,
  parameter int RECOV_CYC = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ce_n,
  input  logic                          we_n,
  input  logic                          oe_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          sup_ok,
  input  logic                          sup_sw,
  input  logic                          sup_full,
  output logic [(1<<BANK_BITS)-1:0]     bank_ce_n,
  output logic [ADDR_W-BANK_BITS-1:0]   mem_addr,
  output logic                          wr_strobe_n,
  output logic                          dout_en,
  output logic                          bat_sel,
  output logic                          proto_err
);
  logic run_nxt;

  pf_supply_mon u_sup (
    .clk      (clk),
    .rst      (rst),
    .sup_ok   (sup_ok),
    .sup_sw   (sup_sw),
    .sup_full (sup_full),
    .run_nxt  (run_nxt),
    .bat_sel  (bat_sel)
  );

  pf_access_ctrl #(
    .ADDR_W    (ADDR_W),
    .BANK_BITS (BANK_BITS),
    .RECOV_CYC (RECOV_CYC)
  ) u_acc (
    .clk         (clk),
    .rst         (rst),
    .run         (run_nxt),
    .ce_n        (ce_n),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .addr        (addr),
    .bank_ce_n   (bank_ce_n),
    .mem_addr    (mem_addr),
    .wr_strobe_n (wr_strobe_n),
    .dout_en     (dout_en),
    .proto_err   (proto_err)
  );
endmodule

// File: rtl/pfsram_ctrl_chk.sv
module pfsram_ctrl_chk #(
  parameter int BANK_BITS = 1,
  parameter int RECOV_CYC = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      sup_ok,
  input logic                      sup_sw,
  input logic [(1<<BANK_BITS)-1:0] bank_ce_n,
  input logic                      wr_strobe_n,
  input logic                      dout_en,
  input logic                      bat_sel,
  input logic                      proto_err
);
  p_one_bank_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bank_ce_n));

  p_strobe_has_bank_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_strobe_n |-> ($countones(~bank_ce_n) == 1));

  p_no_drive_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    !(dout_en && !wr_strobe_n));

  p_fail_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !sup_ok |=> (&bank_ce_n && wr_strobe_n && !dout_en && !proto_err));

  p_bat_follows_r8: assert property (@(posedge clk) disable iff (rst)
    !sup_sw |=> bat_sel);

  p_bat_release_r8: assert property (@(posedge clk) disable iff (rst)
    sup_sw |=> !bat_sel);

  p_err_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> (&bank_ce_n && wr_strobe_n && !dout_en));

  p_recovery_gap_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_strobe_n) && (RECOV_CYC > 0)) |=> wr_strobe_n);
endmodule

bind pfsram_ctrl pfsram_ctrl_chk #(
  .BANK_BITS (BANK_BITS),
  .RECOV_CYC (RECOV_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sup_ok      (sup_ok),
  .sup_sw      (sup_sw),
  .bank_ce_n   (bank_ce_n),
  .wr_strobe_n (wr_strobe_n),
  .dout_en     (dout_en),
  .bat_sel     (bat_sel),
  .proto_err   (proto_err)
);

// File: tb/pfsram_ctrl_tb.sv
`timescale 1ns/1ps
module pfsram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [19:0] addr = '0;
  logic        sup_ok = 1'b0, sup_sw = 1'b0, sup_full = 1'b0;
  logic [1:0]  bank_ce_n;
  logic [18:0] mem_addr;
  logic        wr_strobe_n, dout_en, bat_sel, proto_err;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [int];

  always #4 clk = ~clk;

  pfsram_ctrl #(.ADDR_W(20), .BANK_BITS(1), .RECOV_CYC(2)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .sup_ok(sup_ok), .sup_sw(sup_sw), .sup_full(sup_full),
    .bank_ce_n(bank_ce_n), .mem_addr(mem_addr), .wr_strobe_n(wr_strobe_n),
    .dout_en(dout_en), .bat_sel(bat_sel), .proto_err(proto_err)
  );

  typedef struct packed {
    logic       ce, we, oe, a19;
    logic [3:0] lo;
    logic       ok, sw, full;
    logic [1:0] bce;
    logic       wr, dout, err, bat;
    logic [3:0] req;
  } vec_t;

  // fields: ce we oe a19 lo ok sw full | bce wr dout err bat | req
  localparam vec_t VECS [20] = '{
    '{1,1,1,0,4'h0, 0,0,0, 2'b11,1,0,0,1, 4'd8},  // R8 locked, battery
    '{0,1,0,0,4'h1, 1,1,0, 2'b11,1,0,0,0, 4'd7},  // R7 fail level only
    '{0,1,0,0,4'h2, 1,1,1, 2'b10,1,1,0,0, 4'd2},  // R2 read bank0
    '{0,1,0,1,4'h3, 1,1,0, 2'b01,1,1,0,0, 4'd3},  // R3 R7 bank1, hold run
    '{0,1,1,1,4'h4, 1,1,1, 2'b01,1,0,0,0, 4'd10}, // R10 oe high
    '{0,0,1,0,4'h5, 1,1,1, 2'b10,0,0,0,0, 4'd4},  // R4 write bank0
    '{1,1,1,0,4'h5, 1,1,1, 2'b11,1,0,0,0, 4'd4},  // R4 write ends
    '{0,1,0,0,4'h6, 1,1,1, 2'b11,1,0,1,0, 4'd9},  // R9 blocked
    '{0,1,0,0,4'h6, 1,1,1, 2'b11,1,0,1,0, 4'd9},  // R9 blocked
    '{0,1,0,0,4'h6, 1,1,1, 2'b10,1,1,0,0, 4'd9},  // R9 window over
    '{0,0,0,0,4'h6, 1,1,1, 2'b10,0,0,0,0, 4'd5},  // R5 we falls in read
    '{1,1,1,0,4'h6, 1,1,1, 2'b11,1,0,0,0, 4'd4},
    '{1,1,1,0,4'h0, 1,1,1, 2'b11,1,0,0,0, 4'd9},  // R9 idle no error
    '{1,1,1,0,4'h0, 1,1,1, 2'b11,1,0,0,0, 4'd9},
    '{0,0,1,1,4'h7, 1,1,1, 2'b01,0,0,0,0, 4'd3},  // R3 write bank1
    '{0,0,1,1,4'h7, 0,1,0, 2'b11,1,0,0,0, 4'd6},  // R6 abort mid-write
    '{0,1,0,1,4'h7, 0,0,0, 2'b11,1,0,0,1, 4'd8},  // R8 battery on
    '{0,1,0,1,4'h7, 1,1,0, 2'b11,1,0,0,0, 4'd7},  // R7 still locked
    '{0,1,0,1,4'h8, 1,1,1, 2'b01,1,1,0,0, 4'd6},  // R6 window cleared
    '{0,1,0,0,4'h9, 0,1,1, 2'b11,1,0,0,0, 4'd11}  // R11 no error locked
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic o,
                      input logic [19:0] a, input logic ok, input logic sw,
                      input logic fl, input logic [7:0] wd);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = a;
    sup_ok = ok; sup_sw = sw; sup_full = fl;
    @(posedge clk);
    #1;
    if (!wr_strobe_n)
      shadow[(bank_ce_n == 2'b01 ? 32'h80000 : 32'h0) + mem_addr] = wd;
  endtask

  function automatic logic [7:0] rd_shadow();
    int k;
    k = (bank_ce_n == 2'b01 ? 32'h80000 : 32'h0) + mem_addr;
    return shadow.exists(k) ? shadow[k] : 8'h00;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "bank_ce_n", bank_ce_n, 2'b11);
    chk("R1", "strobe", wr_strobe_n, 1'b1);
    chk("R1", "dout_en", dout_en, 1'b0);
    chk("R1", "bat_sel", bat_sel, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    foreach (VECS[i]) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      step(VECS[i].ce, VECS[i].we, VECS[i].oe,
           {VECS[i].a19, 15'h0, VECS[i].lo},
           VECS[i].ok, VECS[i].sw, VECS[i].full, 8'h00);
      chk(tag, "bank_ce_n", bank_ce_n, VECS[i].bce);
      chk(tag, "strobe", wr_strobe_n, VECS[i].wr);
      chk(tag, "dout_en", dout_en, VECS[i].dout);
      chk(tag, "proto_err", proto_err, VECS[i].err);
      chk(tag, "bat_sel", bat_sel, VECS[i].bat);
      if (VECS[i].bce != 2'b11)
        chk(tag, "mem_addr", mem_addr, {15'h0, VECS[i].lo});
    end

    // R3 R6 routing and protection through the shadow memory
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(0,0,1,20'h80012, 1,1,1, 8'hA5);
    chk("R3", "mem_addr", mem_addr, 19'h00012);
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(0,0,1,20'h00012, 1,1,1, 8'h3C);
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(0,0,1,20'h80012, 0,1,0, 8'hFF);
    chk("R6", "strobe in fail", wr_strobe_n, 1'b1);
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(0,1,0,20'h80012, 1,1,1, 8'h00);
    chk("R3", "bank1 read en", dout_en, 1'b1);
    chk("R6", "bank1 byte", rd_shadow(), 8'hA5);
    step(0,1,0,20'h00012, 1,1,1, 8'h00);
    chk("R3", "bank0 byte", rd_shadow(), 8'h3C);

    // R9 write ended by we_n with ce_n held low
    step(0,0,1,20'h00020, 1,1,1, 8'h11);
    step(0,1,0,20'h00020, 1,1,1, 8'h00);
    chk("R9", "err at we rise", proto_err, 1'b1);
    chk("R9", "no read at we rise", dout_en, 1'b0);

    // R1 reset during an active read
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(1,1,1,20'h0, 1,1,1, 8'h00);
    step(0,1,0,20'h00001, 1,0,1, 8'h00);
    chk("R2", "read before reset", dout_en, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "bank_ce_n reset", bank_ce_n, 2'b11);
    chk("R1", "dout_en reset", dout_en, 1'b0);
    chk("R1", "bat_sel reset", bat_sel, 1'b1);
    chk("R1", "proto_err reset", proto_err, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule